// File: doc/BRIEF.md
# Multi-Format Asynchronous Serial Transmitter with Break Generation

This block turns host words into asynchronous serial frames on a single line, `txd`. The host sets the frame shape through static configuration inputs. These select a word length of five to eight bits, parity off, even or odd, and an optional ninth address bit for multi-drop buses. They also select a stop period of one, one and a half, two or two and a half bit times, followed by a programmable idle gap of whole bit times. All bit timing is counted in pulses of an external 16x oversampling enable, `tick16`, so one bit lasts sixteen pulses.

A word is handed over with a `tx_valid`/`tx_ready` handshake. A separate `brk_req` command sends a break instead. The line is held low for a programmed number of bit times and then returned high for one bit time before the next request is taken. The active-low clear-to-send input `cts_n` lets the block start a new frame or break only at a frame boundary, so a frame that has begun always runs to its end. The configuration is captured when a request is accepted. Changes made while a frame is on the line therefore do not affect that frame.

Top module: `uatx_top`

## Requirements
- R1: After reset, and whenever no frame or break is in progress, `txd` is 1 and `busy` is 0. `tx_ready` is 1 exactly when the block is idle and `cts_n` is 0.
- R2: An accepted word (`tx_valid` and `tx_ready` high at a clock edge, `brk_req` low) is sent as follows: a start bit at 0, then data bits least significant first. Each bit lasts 16 `tick16` pulses counted from the edge after acceptance. The number of data bits is 5 + `cfg_len` (encodings 0..3 give 5..8 bits). Higher data bits are not sent.
- R3: `cfg_par` selects the parity: 0 and 3 give none, 1 gives even and 2 gives odd. The parity bit covers the sent data bits and the address bit when present. It is sent last, after the data and after the address bit.
- R4: When `cfg_addr_en` is 1, the value of `tx_addr` is sent as one extra bit directly after the data bits.
- R5: After the last frame bit the line is 1 for a stop period of 16 + 8*`cfg_stop` ticks (`cfg_stop` 0,1,2,3 give 1, 1.5, 2, 2.5 bits). `busy` falls when that period ends, unless a gap is set.
- R6: `cfg_gap` extends the high stop period by 16*`cfg_gap` ticks before the block becomes idle again.
- R7: `brk_req` high while `tx_ready` is 1 starts a break, even when `tx_valid` is also high. The line is 0 for 16*N ticks, where N is `cfg_brk_len`, and a value of 0 counts as 1. The line is then 1 for 16 ticks before idle.
- R8: While `cts_n` is 1 no frame or break starts, and `tx_ready` stays 0. A rise of `cts_n` during a frame does not shorten or alter that frame.
- R9: The configuration inputs are captured at acceptance. Changing them during a frame leaves that frame's bits and length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | 16x oversampling enable, one-cycle pulses |
| cts_n | input | 1 | Clear to send, active low |
| cfg_len | input | 2 | Word length code, 5 + value bits |
| cfg_par | input | 2 | Parity select: 0/3 none, 1 even, 2 odd |
| cfg_addr_en | input | 1 | Send the address bit after the data |
| cfg_stop | input | 2 | Stop length code, 16 + 8*value ticks |
| cfg_gap | input | GAP_W | Extra idle bit times after stop |
| cfg_brk_len | input | BRK_W | Break length in bit times (0 treated as 1) |
| tx_valid | input | 1 | Word available |
| tx_data | input | DW | Word to send |
| tx_addr | input | 1 | Address bit value |
| brk_req | input | 1 | Break command |
| tx_ready | output | 1 | Block accepts a word or break this cycle |
| busy | output | 1 | Frame or break in progress |
| txd | output | 1 | Serial line, idle high |

## Verification
The bench samples the line at every oversampling pulse of each frame and compares the whole waveform and its length in ticks against a frame model built from the requirements.

The vectors cover the following corner cases, each with the failure it would expose:
- Every word length and both parity senses: a design that mis-ordered the address and parity bits would shift one bit by sixteen ticks.
- Half-bit stop lengths: a design that rounded the half-bit stop lengths would shift the return to idle by eight ticks.
- A reconfiguration in mid-frame: a design that read the configuration live would change the frame length.
- A clear-to-send rise in mid-frame: a design that gated each bit instead of each frame would stall.
- A break of zero length, and a break requested together with a word: a design that mishandled these would send a frame or no low period at all.

// File: rtl/uatx_pkg.sv
// Package: shared types and timing constants for the serial transmitter.
// Assumes a 16x oversampling enable drives all bit timing.
package uatx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SHIFT  = 3'd1,
        ST_STOP   = 3'd2,
        ST_BRK    = 3'd3,
        ST_BRKREC = 3'd4
    } uatx_state_e;

    typedef enum logic [1:0] {
        PAR_OFF  = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_OFF2 = 2'd3
    } uatx_par_e;

endpackage

// File: rtl/uatx_framer.sv
// Module: combinational frame builder. Places start bit, data (LSB first),
// optional address bit and optional parity bit into a bit vector and reports
// how many bits are valid. Assumes DW >= 4 so the length code spans DW-3..DW.
module uatx_framer #(
    parameter int DW = 8,
    localparam int FW = DW + 3,
    localparam int NB_W = $clog2(FW + 1)
) (
    input  logic [1:0]      len,
    input  logic [1:0]      par,
    input  logic            addr_en,
    input  logic            addr,
    input  logic [DW-1:0]   data,
    output logic [FW-1:0]   frame,
    output logic [NB_W-1:0] nbits
);
    import uatx_pkg::*;

    localparam int MIN_LEN = DW - 3;

    // Build the frame bits and count them.
    always_comb begin
        int  wlen;
        int  pos;
        logic p;
        frame    = '1;
        frame[0] = 1'b0;
        wlen     = MIN_LEN + int'(len);
        p        = addr_en & addr;
        for (int i = 0; i < DW; i++) begin
            if (i < wlen) begin
                frame[1 + i] = data[i];
                p            = p ^ data[i];
            end
        end
        pos = 1 + wlen;
        if (addr_en) begin
            frame[pos] = addr;
            pos        = pos + 1;
        end
        if (par == PAR_EVEN) begin
            frame[pos] = p;
            pos        = pos + 1;
        end else if (par == PAR_ODD) begin
            frame[pos] = ~p;
            pos        = pos + 1;
        end
        nbits = NB_W'(pos);
    end

endmodule

// File: rtl/uatx_ticktimer.sv
// Module: down-counter of oversampling pulses. A load sets the period in
// ticks; expire pulses with the tick that ends it. Assumes load wins over tick.
module uatx_ticktimer #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt;

    // Final tick of the loaded period.
    assign expire = tick && (cnt == CW'(1));

    // Load a new period or count down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - CW'(1);
        end
    end

    // An expiry without a reload leaves the timer at rest (R5 stop end).
    p_rest_after_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> (cnt == '0));

endmodule

// File: rtl/uatx_top.sv
// Module: serial transmitter top. Accepts a word or a break command at a
// frame boundary when clear-to-send is active, then drives the line from a
// state machine timed by the tick timer. Configuration is captured on accept.
module uatx_top #(
    parameter int DW    = 8,
    parameter int GAP_W = 4,
    parameter int BRK_W = 5,
    parameter int TPB   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             cts_n,
    input  logic [1:0]       cfg_len,
    input  logic [1:0]       cfg_par,
    input  logic             cfg_addr_en,
    input  logic [1:0]       cfg_stop,
    input  logic [GAP_W-1:0] cfg_gap,
    input  logic [BRK_W-1:0] cfg_brk_len,
    input  logic             tx_valid,
    input  logic [DW-1:0]    tx_data,
    input  logic             tx_addr,
    input  logic             brk_req,
    output logic             tx_ready,
    output logic             busy,
    output logic             txd
);
    import uatx_pkg::*;

    localparam int FW    = DW + 3;
    localparam int NB_W  = $clog2(FW + 1);
    localparam int WIDE  = (GAP_W > BRK_W) ? GAP_W : BRK_W;
    localparam int CNT_W = WIDE + $clog2(TPB) + 2;

    uatx_state_e      state;
    logic             txd_q;
    logic [FW-1:0]    shreg;
    logic [NB_W-1:0]  bits_left;
    logic [CNT_W-1:0] stop_q;

    logic [FW-1:0]    frame;
    logic [NB_W-1:0]  nbits;
    logic             take_brk;
    logic             take_frm;
    logic             expire;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic [CNT_W-1:0] stop_total;
    logic [CNT_W-1:0] brk_total;
    logic [BRK_W-1:0] brk_eff;

    uatx_framer #(.DW(DW)) u_framer (
        .len     (cfg_len),
        .par     (cfg_par),
        .addr_en (cfg_addr_en),
        .addr    (tx_addr),
        .data    (tx_data),
        .frame   (frame),
        .nbits   (nbits)
    );

    uatx_ticktimer #(.CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .load     (t_load),
        .load_val (t_val),
        .expire   (expire)
    );

    // Handshake: accept only when idle and the far end is clear.
    assign tx_ready = (state == ST_IDLE) && !cts_n;
    assign take_brk = tx_ready && brk_req;
    assign take_frm = tx_ready && tx_valid && !brk_req;
    assign busy     = (state != ST_IDLE);
    assign txd      = txd_q;

    // Stop-plus-gap and break periods in ticks from the live configuration.
    always_comb begin
        brk_eff    = (cfg_brk_len == '0) ? BRK_W'(1) : cfg_brk_len;
        stop_total = CNT_W'(TPB) + CNT_W'(cfg_stop) * CNT_W'(TPB / 2)
                   + CNT_W'(cfg_gap) * CNT_W'(TPB);
        brk_total  = CNT_W'(brk_eff) * CNT_W'(TPB);
    end

    // Choose when and with what the tick timer is reloaded.
    always_comb begin
        t_load = 1'b0;
        t_val  = CNT_W'(TPB);
        if (take_brk) begin
            t_load = 1'b1;
            t_val  = brk_total;
        end else if (take_frm) begin
            t_load = 1'b1;
        end else if (expire && (state == ST_SHIFT)) begin
            t_load = 1'b1;
            if (bits_left == '0) begin
                t_val = stop_q;
            end
        end else if (expire && (state == ST_BRK)) begin
            t_load = 1'b1;
        end
    end

    // Frame and break sequencing with a registered line output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            txd_q     <= 1'b1;
            shreg     <= '1;
            bits_left <= '0;
            stop_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take_brk) begin
                        state <= ST_BRK;
                        txd_q <= 1'b0;
                    end else if (take_frm) begin
                        state     <= ST_SHIFT;
                        txd_q     <= frame[0];
                        shreg     <= frame >> 1;
                        bits_left <= nbits - NB_W'(1);
                        stop_q    <= stop_total;
                    end
                end
                ST_SHIFT: begin
                    if (expire) begin
                        if (bits_left == '0) begin
                            state <= ST_STOP;
                            txd_q <= 1'b1;
                        end else begin
                            txd_q     <= shreg[0];
                            shreg     <= shreg >> 1;
                            bits_left <= bits_left - NB_W'(1);
                        end
                    end
                end
                ST_STOP: begin
                    if (expire) begin
                        state <= ST_IDLE;
                    end
                end
                ST_BRK: begin
                    if (expire) begin
                        state <= ST_BRKREC;
                        txd_q <= 1'b1;
                    end
                end
                ST_BRKREC: begin
                    if (expire) begin
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    txd_q <= 1'b1;
                end
            endcase
        end
    end

    // Idle line is high.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> txd_q);

    // Accepted word opens with a low start bit.
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_frm |=> (!txd_q && (state == ST_SHIFT)));

    // Stop and gap period keeps the line high.
    p_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |-> txd_q);

    // Break wins over a word offered in the same cycle.
    p_brk_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && brk_req) |=> ((state == ST_BRK) && !txd_q));

    // Nothing starts while clear-to-send is inactive.
    p_cts_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && cts_n) |=> (state == ST_IDLE));

endmodule

// File: tb/sim_uatx_top.sv
// Bench: vector table of frame formats walked by one loop, then directed
// tests for reset, flow control, mid-frame changes and breaks.
module sim_uatx_top;

    localparam int DW = 8, GAP_W = 4, BRK_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick16 = 1'b0;
    logic             cts_n = 1'b0;
    logic [1:0]       cfg_len = '0;
    logic [1:0]       cfg_par = '0;
    logic             cfg_addr_en = 1'b0;
    logic [1:0]       cfg_stop = '0;
    logic [GAP_W-1:0] cfg_gap = '0;
    logic [BRK_W-1:0] cfg_brk_len = '0;
    logic             tx_valid = 1'b0;
    logic [DW-1:0]    tx_data = '0;
    logic             tx_addr = 1'b0;
    logic             brk_req = 1'b0;
    logic             tx_ready, busy, txd;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;
    always @(negedge clk) tick16 = ~tick16;

    uatx_top #(.DW(DW), .GAP_W(GAP_W), .BRK_W(BRK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .cts_n(cts_n),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_addr_en(cfg_addr_en),
        .cfg_stop(cfg_stop), .cfg_gap(cfg_gap), .cfg_brk_len(cfg_brk_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_addr(tx_addr),
        .brk_req(brk_req), .tx_ready(tx_ready), .busy(busy), .txd(txd)
    );

    // Vector fields: len[19:18] par[17:16] aen[15] addr[14] stop[13:12] gap[11:8] data[7:0]
    localparam logic [19:0] VEC [8] = '{
        {2'd3, 2'd0, 1'b0, 1'b0, 2'd0, 4'd0, 8'hA5},
        {2'd0, 2'd1, 1'b0, 1'b0, 2'd1, 4'd0, 8'h13},
        {2'd1, 2'd2, 1'b0, 1'b0, 2'd2, 4'd1, 8'h2C},
        {2'd2, 2'd1, 1'b1, 1'b1, 2'd3, 4'd0, 8'h7F},
        {2'd3, 2'd2, 1'b1, 1'b0, 2'd0, 4'd2, 8'h00},
        {2'd3, 2'd3, 1'b1, 1'b1, 2'd1, 4'd0, 8'hFF},
        {2'd0, 2'd2, 1'b0, 1'b0, 2'd3, 4'd3, 8'h1F},
        {2'd2, 2'd0, 1'b0, 1'b0, 2'd2, 4'd0, 8'h80}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Send one word and compare every tick-level sample and the length.
    task automatic send_frame(input logic [19:0] v, input bit mid_cfg, input bit mid_cts,
                              input string tag_pat, input string tag_len);
        logic [10:0] eb;
        int nb, total, k, err, wl, lvl;
        logic p;
        cfg_len = v[19:18]; cfg_par = v[17:16]; cfg_addr_en = v[15];
        tx_addr = v[14]; cfg_stop = v[13:12]; cfg_gap = v[11:8]; tx_data = v[7:0];
        wl = 5 + int'(v[19:18]);
        eb = '1; eb[0] = 1'b0; p = v[15] & v[14];
        for (int i = 0; i < wl; i++) begin
            eb[1 + i] = v[i];
            p = p ^ v[i];
        end
        nb = 1 + wl;
        if (v[15]) begin eb[nb] = v[14]; nb++; end
        if (v[17:16] == 2'd1) begin eb[nb] = p; nb++; end
        else if (v[17:16] == 2'd2) begin eb[nb] = ~p; nb++; end
        total = 16 * nb + 16 + 8 * int'(v[13:12]) + 16 * int'(v[11:8]);
        step();
        while (!tx_ready) step();
        tx_valid = 1'b1;
        step();
        tx_valid = 1'b0;
        if (mid_cfg) begin
            cfg_len = ~cfg_len; cfg_par = ~cfg_par; cfg_addr_en = ~cfg_addr_en;
            cfg_stop = ~cfg_stop; cfg_gap = cfg_gap + 4'd5; tx_data = ~tx_data;
        end
        if (mid_cts) cts_n = 1'b1;
        k = 0; err = 0;
        while (busy && k < 4000) begin
            if (tick16) begin
                lvl = (k / 16 < nb) ? int'(eb[k / 16]) : 1;
                if (int'(txd) != lvl) err++;
                k++;
            end
            step();
        end
        chk(err == 0, tag_pat, err, 0);
        chk(k == total, tag_len, k, total);
        cts_n = 1'b0;
    endtask

    // Send one break, optionally with a word offered in the same cycle.
    task automatic send_break(input logic [BRK_W-1:0] n, input bit with_word);
        int neff, k, err, lvl;
        neff = (n == 0) ? 1 : int'(n);
        cfg_brk_len = n;
        step();
        while (!tx_ready) step();
        brk_req = 1'b1; tx_valid = with_word;
        step();
        brk_req = 1'b0; tx_valid = 1'b0;
        k = 0; err = 0;
        while (busy && k < 4000) begin
            if (tick16) begin
                lvl = (k < 16 * neff) ? 0 : 1;
                if (int'(txd) != lvl) err++;
                k++;
            end
            step();
        end
        chk(err == 0, "R7 break level", err, 0);
        chk(k == 16 * (neff + 1), "R7 break length", k, 16 * (neff + 1));
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int bad;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
        chk(tx_ready == 1'b1, "R1 reset ready", int'(tx_ready), 1);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);

        // Table walk: R2 R3 R4 bits, R5 R6 length
        foreach (VEC[i]) begin
            send_frame(VEC[i], 1'b0, 1'b0, "R2 R3 R4 frame bits", "R5 R6 frame length");
        end

        // R8: clear-to-send inactive blocks a waiting word
        cts_n = 1'b1; tx_valid = 1'b1; bad = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (busy || !txd || tx_ready) bad++;
        end
        tx_valid = 1'b0;
        chk(bad == 0, "R8 blocked while cts_n high", bad, 0);
        cts_n = 1'b0;

        // R8: clear-to-send rising mid-frame does not cut the frame
        send_frame(VEC[3], 1'b0, 1'b1, "R8 frame bits with cts_n rise", "R8 frame length with cts_n rise");

        // R9: configuration changed mid-frame is ignored
        send_frame(VEC[2], 1'b1, 1'b0, "R9 frame bits after cfg change", "R9 frame length after cfg change");

        // R7: break with a competing word, and zero length
        send_break(5'd3, 1'b1);
        send_break(5'd0, 1'b0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule